// File: doc/BRIEF.md
# Two-TAP JTAG Scan Chain

This block holds two IEEE 1149.1 test access ports in series on one set of pins. Both ports share the test clock, mode select and asynchronous reset. Serial data enters the test port first. The test port has a 5-bit instruction register, and its serial output feeds the debug port. The debug port has a 4-bit instruction register and drives the chip's serial output. Each port has the standard sixteen-state controller, a 32-bit identification register and a one-bit bypass register.

A debugger that wants only the debug port parks the test port in bypass. It then sees a 9-bit instruction path and one extra data bit per scan. A separate select input retires the test port for serial-wire operation. While that input is high, the test port sees mode select stuck at one, so it stays in its reset state. Its serial output also hands the input data straight to the debug port, so the debug port stays reachable through a 4-bit instruction path with no extra data bit.

Top module: `jtag_dual_chain`

## Requirements
- R1: An instruction scan passes through a 9-bit path. The capture value in each port has 01 in its two lowest bits and zeros above. So the first nine output bits, in shift order, are 1,0,0,0,1,0,0,0,0, and input bits reappear at the output nine shifts later.
- R2: Of the nine bits shifted into the instruction path, the first four land in the debug port and the last five land in the test port. The debug port's bits sit nearest the serial output.
- R3: The all-ones instruction (5'b11111 for the test port, 4'b1111 for the debug port) selects a one-bit bypass register that captures 0. Each port in bypass adds exactly one bit to the data path.
- R4: After reset both ports select their identification register. A 64-bit data scan returns the debug port's 32-bit code first and the test port's code after it, least significant bit first. Each code has bit 0 set.
- R5: An instruction that is neither the identification opcode nor all ones selects the bypass register.
- R6: Pulling the reset input low forces both controllers to the reset state at once, without a clock edge. The serial output goes high-impedance immediately.
- R7: Five rising clock edges with mode select high bring both controllers to the reset state from any state, and the identification instruction is restored.
- R8: The serial output is high-impedance in every state except the two shift states. The input is sampled on the rising clock edge, and the output changes on the falling edge.
- R9: While the serial-wire select is high, the test port is held in its reset state and passes input data straight through. Instruction scans are then 4 bits long, and an identification data scan returns only the debug port's 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock shared by both ports |
| trstN | input | 1 | Asynchronous reset of both controllers, active low |
| tms | input | 1 | Mode select shared by both ports |
| tdi | input | 1 | Serial data into the test port |
| swSelect | input | 1 | Serial-wire select; high retires the test port |
| tdo | output | 1 | Serial data out of the debug port, tristated outside shift states |

## Verification
The bench builds the block with instruction widths of 5 and 4, identification opcodes 5'b11110 and 4'b1110, and the two distinct codes 32'h7E57_1A2B and 32'h4C0D_E0A1. With unequal widths and distinct codes, any mix-up of which port holds which bits shows up in the output stream. Padding scans longer than the path show where the chain ends. Shifting a known pattern past the captured values measures the path length in the 9-bit, 4-bit, bypass and serial-wire cases.

// File: rtl/jtag_pkg.sv
package jtag_pkg;

  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, UPD_IR
  } tapState_e;

  typedef struct packed {
    logic resetSt;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t st
);

  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      TLR:      nextState = tms ? TLR      : RTI;
      RTI:      nextState = tms ? SEL_DR   : RTI;
      SEL_DR:   nextState = tms ? SEL_IR   : CAP_DR;
      CAP_DR:   nextState = tms ? EXIT1_DR : SHIFT_DR;
      SHIFT_DR: nextState = tms ? EXIT1_DR : SHIFT_DR;
      EXIT1_DR: nextState = tms ? UPD_DR   : PAUSE_DR;
      PAUSE_DR: nextState = tms ? EXIT2_DR : PAUSE_DR;
      EXIT2_DR: nextState = tms ? UPD_DR   : SHIFT_DR;
      UPD_DR:   nextState = tms ? SEL_DR   : RTI;
      SEL_IR:   nextState = tms ? TLR      : CAP_IR;
      CAP_IR:   nextState = tms ? EXIT1_IR : SHIFT_IR;
      SHIFT_IR: nextState = tms ? EXIT1_IR : SHIFT_IR;
      EXIT1_IR: nextState = tms ? UPD_IR   : PAUSE_IR;
      PAUSE_IR: nextState = tms ? EXIT2_IR : PAUSE_IR;
      EXIT2_IR: nextState = tms ? UPD_IR   : SHIFT_IR;
      UPD_IR:   nextState = tms ? SEL_DR   : RTI;
      default:  nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= nextState;
  end

  always_comb begin
    st.resetSt   = (state == TLR);
    st.captureIr = (state == CAP_IR);
    st.shiftIr   = (state == SHIFT_IR);
    st.updateIr  = (state == UPD_IR);
    st.captureDr = (state == CAP_DR);
    st.shiftDr   = (state == SHIFT_DR);
  end

  AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (state == TLR && tms) |=> (state == TLR)); // R7

  AST_SHIFT_IR_ENTRY: assert property (@(posedge tck) disable iff (!trstN)
    $rose(st.shiftIr) |-> ($past(state) == CAP_IR || $past(state) == EXIT2_IR)); // R1

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import jtag_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] ID_OP  = '1 - 1'b1,
  parameter logic [ID_W-1:0] IDCODE = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  tapStrobe_t st,
  output logic       tdoBit,
  output logic       tdoOe
);

  localparam logic [IR_W-1:0] BYP_OP  = '1;
  localparam logic [IR_W-1:0] IR_CAPT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] irShift, irOp;
  logic [ID_W-1:0] idShift;
  logic            bypReg;
  logic            isId;
  logic            serialOut;

  assign isId = (irOp == ID_OP);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irOp    <= ID_OP;
      idShift <= '0;
      bypReg  <= 1'b0;
    end else begin
      if (st.resetSt)       irOp <= ID_OP;
      else if (st.updateIr) irOp <= irShift;

      if (st.captureIr)    irShift <= IR_CAPT;
      else if (st.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};

      if (st.captureDr) begin
        if (isId) idShift <= IDCODE;
        else      bypReg  <= 1'b0;
      end else if (st.shiftDr) begin
        if (isId) idShift <= {tdi, idShift[ID_W-1:1]};
        else      bypReg  <= tdi;
      end
    end
  end

  always_comb begin
    if (st.shiftIr)  serialOut = irShift[0];
    else if (isId)   serialOut = idShift[0];
    else             serialOut = bypReg;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoBit <= 1'b0;
      tdoOe  <= 1'b0;
    end else begin
      tdoBit <= serialOut;
      tdoOe  <= st.shiftIr | st.shiftDr;
    end
  end

  AST_IR_DEFAULT: assert property (@(posedge tck) disable iff (!trstN)
    st.resetSt |=> (irOp == ID_OP)); // R4

  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trstN)
    (st.captureDr && !isId) |=> (bypReg == 1'b0)); // R3

  AST_BYP_ALLONES: assert property (@(posedge tck) disable iff (!trstN)
    (irOp == BYP_OP) |-> !isId); // R3

endmodule

// File: rtl/jtag_dual_chain.sv
module jtag_dual_chain
  import jtag_pkg::*;
#(
  parameter int                   TEST_IR_W   = 5,
  parameter int                   CORE_IR_W   = 4,
  parameter logic [TEST_IR_W-1:0] TEST_ID_OP  = 5'b11110,
  parameter logic [CORE_IR_W-1:0] CORE_ID_OP  = 4'b1110,
  parameter logic [ID_W-1:0]      TEST_IDCODE = 32'h7E57_1A2B,
  parameter logic [ID_W-1:0]      CORE_IDCODE = 32'h4C0D_E0A1
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic swSelect,
  output logic tdo
);

  localparam int RESET_EDGES = 5;

  tapStrobe_t testSt, coreSt;
  logic       testTms;
  logic       testBit, testOe, coreBit, coreOe;
  logic       linkBit;

  assign testTms = tms | swSelect;

  tap_ctrl u_testCtrl (.tck(tck), .trstN(trstN), .tms(testTms), .st(testSt));

  tap_datapath #(.IR_W(TEST_IR_W), .ID_OP(TEST_ID_OP), .IDCODE(TEST_IDCODE)) u_testDp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .st(testSt), .tdoBit(testBit), .tdoOe(testOe)
  );

  assign linkBit = (swSelect || !testOe) ? tdi : testBit;

  tap_ctrl u_coreCtrl (.tck(tck), .trstN(trstN), .tms(tms), .st(coreSt));

  tap_datapath #(.IR_W(CORE_IR_W), .ID_OP(CORE_ID_OP), .IDCODE(CORE_IDCODE)) u_coreDp (
    .tck(tck), .trstN(trstN), .tdi(linkBit), .st(coreSt), .tdoBit(coreBit), .tdoOe(coreOe)
  );

  assign tdo = coreOe ? coreBit : 1'bz;

  logic [2:0] swCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                   swCnt <= '0;
    else if (!swSelect)           swCnt <= '0;
    else if (swCnt != RESET_EDGES) swCnt <= swCnt + 3'd1;
  end

  AST_SW_PARKED: assert property (@(posedge tck) disable iff (!trstN)
    (swCnt == RESET_EDGES) |-> testSt.resetSt); // R9

endmodule

// File: tb/sim_jtag_dual_chain.sv
`timescale 1ns/1ps
module sim_jtag_dual_chain;

  localparam logic [31:0] TID = 32'h7E57_1A2B;
  localparam logic [31:0] CID = 32'h4C0D_E0A1;
  localparam logic [4:0]  TOP = 5'b11110;
  localparam logic [3:0]  COP = 4'b1110;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0, swSelect = 1'b0;
  wire  tdo;
  int   total = 0, bad = 0;
  logic [127:0] din, dout;
  logic tmp;

  always #2 tck = ~tck;

  jtag_dual_chain #(.TEST_IR_W(5), .CORE_IR_W(4), .TEST_ID_OP(TOP), .CORE_ID_OP(COP),
    .TEST_IDCODE(TID), .CORE_IDCODE(CID)) u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .swSelect(swSelect), .tdo(tdo));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = t; tdi = d;
  endtask

  task automatic goReset();
    logic o;
    repeat (5) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic shiftBits(input int n, input logic [127:0] v, output logic [127:0] r);
    logic o;
    r = '0;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, v[i], o);
      r[i] = o;
    end
    tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic irScan(input int n, input logic [127:0] v, output logic [127:0] r);
    logic o;
    tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
    shiftBits(n, v, r);
  endtask

  task automatic drScan(input int n, input logic [127:0] v, output logic [127:0] r);
    logic o;
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
    shiftBits(n, v, r);
  endtask

  task automatic testIdAfterReset(input string req);
    logic [127:0] v, r;
    v = 128'h0;
    drScan(64, v, r);
    chk(req, r[63:0], {TID, CID});
  endtask

  task automatic t_reset();
    #1;
    chk("R8 tdo z in reset", {127'd0, tdo}, {127'd0, 1'bz});
    trstN = 1'b1;
    goReset();
    chk("R8 tdo z in idle", {127'd0, tdo}, {127'd0, 1'bz});
    testIdAfterReset("R4 idcodes after reset");
    chk("R4 idcode bit0", {126'd0, TID[0], CID[0]}, 128'd3);
  endtask

  task automatic t_irChain();
    logic [127:0] r;
    irScan(13, {115'd0, 5'b11111, 4'b1111, 4'b1010}, r);
    chk("R1 ir capture", {119'd0, r[8:0]}, {119'd0, 9'b000010001});
    chk("R1 ir length 9", {124'd0, r[12:9]}, {124'd0, 4'b1010});
    drScan(10, {118'd0, 10'b1101001101}, r);
    chk("R3 bypass capture zeros", {126'd0, r[1:0]}, 128'd0);
    chk("R3 two bypass bits", {120'd0, r[9:2]}, {120'd0, 8'b01001101});
  endtask

  task automatic t_order();
    logic [127:0] r;
    irScan(9, {119'd0, 5'b11111, COP}, r);
    drScan(40, {88'd0, 40'hA5_0000_0000}, r);
    chk("R2 core id first", {96'd0, r[31:0]}, {96'd0, CID});
    chk("R2 test bypass bit", {127'd0, r[32]}, 128'd0);
    chk("R2 tdi after 33", {121'd0, r[39:33]}, 128'd0);
    irScan(9, {119'd0, TOP, 4'b1111}, r);
    drScan(33, 128'd0, r);
    chk("R2 core bypass first", {127'd0, r[0]}, 128'd0);
    chk("R2 test id second", {96'd0, r[32:1]}, {96'd0, TID});
  endtask

  task automatic t_unknown();
    logic [127:0] r;
    irScan(9, {119'd0, 5'b11111, 4'b0101}, r);
    drScan(6, {122'd0, 6'b101100}, r);
    chk("R5 core unknown op is bypass", {122'd0, r[5:0]}, {122'd0, 6'b110000});
    irScan(9, {119'd0, 5'b00110, 4'b1111}, r);
    drScan(6, {122'd0, 6'b011100}, r);
    chk("R5 test unknown op is bypass", {122'd0, r[5:0]}, {122'd0, 6'b110000});
  endtask

  task automatic t_tmsReset();
    logic [127:0] r;
    irScan(9, {119'd0, 9'h1FF}, r);
    tick(1'b1, 1'b0, tmp); tick(1'b0, 1'b0, tmp); tick(1'b0, 1'b0, tmp);
    tick(1'b0, 1'b0, tmp);
    goReset();
    testIdAfterReset("R7 five tms high restores idcode");
  endtask

  task automatic t_trst();
    logic [127:0] r;
    irScan(9, {119'd0, 9'h1FF}, r);
    tick(1'b1, 1'b0, tmp); tick(1'b0, 1'b0, tmp); tick(1'b0, 1'b0, tmp);
    tick(1'b0, 1'b1, tmp); tick(1'b0, 1'b1, tmp);
    chk("R8 tdo driven in shift", {127'd0, tdo === 1'bz}, 128'd0);
    trstN = 1'b0;
    #0.5;
    chk("R6 async tdo z", {127'd0, tdo}, {127'd0, 1'bz});
    #1; trstN = 1'b1;
    tick(1'b0, 1'b0, tmp);
    testIdAfterReset("R6 idcode after trst");
  endtask

  task automatic t_sw();
    logic [127:0] r;
    swSelect = 1'b1;
    goReset();
    irScan(8, {120'd0, 4'b0110, 4'b1111}, r);
    chk("R9 ir capture 4", {124'd0, r[3:0]}, {124'd0, 4'b0001});
    chk("R9 ir length 4", {124'd0, r[7:4]}, {124'd0, 4'b1111});
    drScan(5, {123'd0, 5'b10110}, r);
    chk("R9 one bypass bit", {123'd0, r[4:0]}, {123'd0, 5'b01100});
    goReset();
    drScan(40, {88'd0, 40'h5A_0000_0000}, r);
    chk("R9 core id only", {96'd0, r[31:0]}, {96'd0, CID});
    chk("R9 passthrough", {120'd0, r[39:32]}, 128'd0);
    swSelect = 1'b0;
    goReset();
    testIdAfterReset("R9 chain restored");
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_irChain();
    t_order();
    t_unknown();
    t_tmsReset();
    t_trst();
    t_sw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule